// File: doc/BRIEF.md
# Audio Playback Chunk Fetcher

This block streams PCM audio out of a memory buffer. Software programs a first and a last buffer address, optionally asks for the buffer to repeat, and sets a go bit. The block then reads the buffer in 16-byte chunks over a simple request/grant read port. It keeps up to two chunks on hand so that the next chunk is already present when the current one runs out. It hands out one 16-bit sample each time the serial output stage asks for one. A sample counter records how many samples have gone out since playback began.

Two events are recorded: playback has begun, and playback has finished. Each event sets a sticky flag. Software clears a flag by writing a 1 to its bit. An interrupt line is raised whenever a flag is set and its enable bit is set. While playback runs, the address and control registers are frozen, so a write to them is dropped.

Top module: `pcm_fetch`

## Requirements
- R1: After reset, every register reads 0, and `irq`, `mem_req` and `smp_valid` are 0.
- R2: Register 1 (first address) and register 2 (last address) keep bits 27..3 of a write and read 0 in all other bits. Fetch addresses take only bits 27..4, so `mem_addr[3:0]` is always 0. The last address is inclusive.
- R3: While playback runs (register 0 bit 0 reads 1), writes to registers 0, 1 and 2 are ignored. The read-back values and the playback in progress are unchanged.
- R4: Chunks are fetched at ascending 16-byte addresses from the first chunk to the last chunk, each once, and `mem_req` with `mem_addr` is held steady until `mem_gnt` is seen.
- R5: At most two fetched chunks are held; with no samples taken, exactly two fetches occur and `mem_req` stays low.
- R6: A `smp_req` pulse that finds data gives `smp_valid` with the next sample on the following cycle. Sample k of a chunk comes from `mem_rdata[16k+15:16k]`, and chunks are played in fetch order. With no data held, `smp_valid` stays 0.
- R7: Flag bit 0 of register 3 sets when playback begins. Flag bit 1 sets, and register 0 bit 0 clears, on the cycle after the last sample of a non-looping buffer is delivered. Bit 1 is not set earlier.
- R8: Flags stay set until software writes 1 to the bit in register 3. Writing 0 to a flag bit leaves it unchanged.
- R9: `irq` is the OR over bits of (register 3 AND register 4). It is registered, one cycle behind the flags.
- R10: Register 5 resets to 0 when playback begins. It increases by one for each delivered sample and is otherwise unchanged.
- R11: With register 0 bit 1 (repeat) set at start, fetching continues at the first chunk after the last chunk. Playback does not finish and flag bit 1 stays 0.
- R12: While idle, `smp_req` produces no sample and leaves register 5 unchanged, and `mem_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index: 0 control, 1 first address, 2 last address, 3 event flags, 4 event enables, 5 sample count |
| reg_wdata | input | 32 | Register write data; control bit 0 go, bit 1 repeat |
| reg_rdata | output | 32 | Registered read data for `reg_idx`, one cycle later; control bit 0 busy, bit 1 repeat |
| mem_req | output | 1 | Chunk read request |
| mem_addr | output | 28 | Byte address of the requested chunk |
| mem_gnt | input | 1 | Grant; `mem_rdata` is valid in the same cycle |
| mem_rdata | input | 128 | Chunk data, eight 16-bit samples |
| smp_req | input | 1 | Serial stage asks for the next sample |
| smp_valid | output | 1 | Sample delivered |
| smp_data | output | 16 | Sample value |
| irq | output | 1 | Interrupt, level |

## Verification
On every cycle, the assertions check these properties:
- a pending request holds its address until granted;
- no fetch is made into a full buffer and no chunk is taken from an empty one;
- frozen registers stay unchanged while busy;
- sticky flags survive any write that does not clear them;
- the sample count does not move without a sample.

Some behaviours need the bench's sweeps over buffer sizes, grant latencies and placements near the top of the address space. These are the exact order and values of the samples, the inclusive end chunk, when the finish event fires, and the repeat mode.

// File: rtl/pcm_fetch_pkg.sv
package pcm_fetch_pkg;
  localparam int REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    RI_CTRL      = 3'd0,
    RI_BUF_FIRST = 3'd1,
    RI_BUF_LAST  = 3'd2,
    RI_EVT_FLAGS = 3'd3,
    RI_EVT_EN    = 3'd4,
    RI_POS       = 3'd5
  } reg_idx_e;

  localparam int CTL_GO    = 0;
  localparam int CTL_LOOP  = 1;

  localparam int EVT_BEGIN  = 0;
  localparam int EVT_FINISH = 1;
  localparam int NUM_EVT    = 2;
endpackage

// File: rtl/pcm_fetch_fifo.sv
module pcm_fetch_fifo #(
  parameter int DW    = 128,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DW-1:0]    store [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);
  assign rdata = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/pcm_fetch_regs.sv
module pcm_fetch_regs
  import pcm_fetch_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int ADDR_W    = 28,
  parameter int STORE_LSB = 3,
  parameter int CHUNK_LSB = 4,
  parameter int POS_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reg_we,
  input  logic [REG_IDX_W-1:0]        reg_idx,
  input  logic [REG_W-1:0]            reg_wdata,
  output logic [REG_W-1:0]            reg_rdata,
  input  logic                        play_done,
  input  logic [POS_W-1:0]            pos,
  output logic                        busy,
  output logic                        loop_en,
  output logic                        start_pulse,
  output logic [ADDR_W-1:CHUNK_LSB]   first_chunk,
  output logic [ADDR_W-1:CHUNK_LSB]   last_chunk,
  output logic                        irq
);
  logic [ADDR_W-1:STORE_LSB] first_q, last_q;
  logic                      busy_q, loop_q, irq_q;
  logic [NUM_EVT-1:0]        flags_q, en_q, evt_set, evt_clr;
  logic [REG_W-1:0]          rd_next;
  logic                      cfg_wr, finish;
  logic                      unused_wbits;

  assign unused_wbits = ^reg_wdata;

  assign cfg_wr      = reg_we && !busy_q;
  assign start_pulse = cfg_wr && (reg_idx == RI_CTRL) && reg_wdata[CTL_GO];
  assign finish      = busy_q && play_done;

  assign evt_set[EVT_BEGIN]  = start_pulse;
  assign evt_set[EVT_FINISH] = finish;
  assign evt_clr = (reg_we && reg_idx == RI_EVT_FLAGS) ? reg_wdata[NUM_EVT-1:0] : '0;

  assign busy        = busy_q;
  assign loop_en     = loop_q;
  assign first_chunk = first_q[ADDR_W-1:CHUNK_LSB];
  assign last_chunk  = last_q[ADDR_W-1:CHUNK_LSB];
  assign irq         = irq_q;

  always_comb begin
    rd_next = '0;
    case (reg_idx)
      RI_CTRL: begin
        rd_next[CTL_GO]   = busy_q;
        rd_next[CTL_LOOP] = loop_q;
      end
      RI_BUF_FIRST: rd_next[ADDR_W-1:STORE_LSB] = first_q;
      RI_BUF_LAST:  rd_next[ADDR_W-1:STORE_LSB] = last_q;
      RI_EVT_FLAGS: rd_next[NUM_EVT-1:0]        = flags_q;
      RI_EVT_EN:    rd_next[NUM_EVT-1:0]        = en_q;
      RI_POS:       rd_next[POS_W-1:0]          = pos;
      default:      rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q   <= '0;
      last_q    <= '0;
      loop_q    <= 1'b0;
      busy_q    <= 1'b0;
      flags_q   <= '0;
      en_q      <= '0;
      irq_q     <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (cfg_wr) begin
        case (reg_idx)
          RI_CTRL:      loop_q  <= reg_wdata[CTL_LOOP];
          RI_BUF_FIRST: first_q <= reg_wdata[ADDR_W-1:STORE_LSB];
          RI_BUF_LAST:  last_q  <= reg_wdata[ADDR_W-1:STORE_LSB];
          default: ;
        endcase
      end
      if (reg_we && reg_idx == RI_EVT_EN) en_q <= reg_wdata[NUM_EVT-1:0];
      if (start_pulse)  busy_q <= 1'b1;
      else if (finish)  busy_q <= 1'b0;
      flags_q   <= (flags_q & ~evt_clr) | evt_set;
      irq_q     <= |(flags_q & en_q);
      reg_rdata <= rd_next;
    end
  end

  assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_q && reg_we && (reg_idx == RI_CTRL || reg_idx == RI_BUF_FIRST || reg_idx == RI_BUF_LAST))
      |=> ($stable(first_q) && $stable(last_q) && $stable(loop_q)));
  assert_begin_flag_R7: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> (flags_q[EVT_BEGIN] && busy_q));
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q & $past(flags_q & ~evt_clr)) == $past(flags_q & ~evt_clr)));
endmodule

// File: rtl/pcm_fetch_fetch.sv
module pcm_fetch_fetch #(
  parameter int ADDR_W    = 28,
  parameter int CHUNK_LSB = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_pulse,
  input  logic                      busy,
  input  logic                      loop_en,
  input  logic [ADDR_W-1:CHUNK_LSB] first_chunk,
  input  logic [ADDR_W-1:CHUNK_LSB] last_chunk,
  input  logic                      fifo_full,
  input  logic                      fifo_empty,
  input  logic                      mem_gnt,
  output logic                      mem_req,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic                      push,
  output logic                      play_done
);
  logic [ADDR_W-1:CHUNK_LSB] ptr_q;
  logic                      req_q, done_q;

  assign mem_req   = req_q;
  assign mem_addr  = {ptr_q, {CHUNK_LSB{1'b0}}};
  assign push      = req_q && mem_gnt;
  assign play_done = done_q && fifo_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      req_q  <= 1'b0;
      done_q <= 1'b1;
    end else if (start_pulse) begin
      ptr_q  <= first_chunk;
      req_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (push) begin
      req_q <= 1'b0;
      if (ptr_q == last_chunk) begin
        if (loop_en) ptr_q  <= first_chunk;
        else         done_q <= 1'b1;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end else if (!req_q) begin
      req_q <= busy && !done_q && !fifo_full;
    end
  end

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (req_q && !mem_gnt) |=> (req_q && $stable(ptr_q)));
  assert_no_overfetch_R5: assert property (@(posedge clk) disable iff (rst)
    req_q |-> !fifo_full);
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !req_q);
endmodule

// File: rtl/pcm_fetch_unpack.sv
module pcm_fetch_unpack #(
  parameter int DW       = 128,
  parameter int SAMPLE_W = 16,
  parameter int POS_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_pulse,
  input  logic                busy,
  input  logic                smp_req,
  input  logic                fifo_empty,
  input  logic [DW-1:0]       chunk,
  output logic                pop,
  output logic                smp_valid,
  output logic [SAMPLE_W-1:0] smp_data,
  output logic [POS_W-1:0]    pos
);
  localparam int SPC = DW / SAMPLE_W;
  localparam int IW  = (SPC > 1) ? $clog2(SPC) : 1;

  logic [IW-1:0]    idx_q;
  logic [POS_W-1:0] pos_q;
  logic             take;

  assign take = smp_req && busy && !fifo_empty;
  assign pop  = take && (idx_q == IW'(SPC - 1));
  assign pos  = pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      pos_q     <= '0;
      smp_valid <= 1'b0;
      smp_data  <= '0;
    end else begin
      smp_valid <= take;
      if (take) smp_data <= chunk[int'(idx_q)*SAMPLE_W +: SAMPLE_W];
      if (start_pulse) begin
        idx_q <= '0;
        pos_q <= '0;
      end else if (take) begin
        idx_q <= (idx_q == IW'(SPC - 1)) ? '0 : idx_q + 1'b1;
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assert_valid_after_req_R6: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> $past(smp_req));
  assert_pos_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!take && !start_pulse) |=> $stable(pos_q));
endmodule

// File: rtl/pcm_fetch.sv
module pcm_fetch
  import pcm_fetch_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int ADDR_W    = 28,
  parameter int STORE_LSB = 3,
  parameter int CHUNK_W   = 128,
  parameter int SAMPLE_W  = 16,
  parameter int POS_W     = 16,
  parameter int FIFO_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic [2:0]           reg_idx,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 mem_req,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic                 mem_gnt,
  input  logic [CHUNK_W-1:0]   mem_rdata,
  input  logic                 smp_req,
  output logic                 smp_valid,
  output logic [SAMPLE_W-1:0]  smp_data,
  output logic                 irq
);
  localparam int CHUNK_LSB = $clog2(CHUNK_W / 8);

  logic                      busy, loop_en, start_pulse, play_done;
  logic [ADDR_W-1:CHUNK_LSB] first_chunk, last_chunk;
  logic [POS_W-1:0]          pos;
  logic                      push, pop, fifo_full, fifo_empty;
  logic [CHUNK_W-1:0]        chunk;

  pcm_fetch_regs #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .STORE_LSB(STORE_LSB),
    .CHUNK_LSB(CHUNK_LSB), .POS_W(POS_W)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .play_done(play_done),
    .pos(pos), .busy(busy), .loop_en(loop_en), .start_pulse(start_pulse),
    .first_chunk(first_chunk), .last_chunk(last_chunk), .irq(irq)
  );

  pcm_fetch_fetch #(.ADDR_W(ADDR_W), .CHUNK_LSB(CHUNK_LSB)) u_fetch (
    .clk(clk), .rst(rst), .start_pulse(start_pulse), .busy(busy),
    .loop_en(loop_en), .first_chunk(first_chunk), .last_chunk(last_chunk),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .mem_gnt(mem_gnt),
    .mem_req(mem_req), .mem_addr(mem_addr), .push(push), .play_done(play_done)
  );

  pcm_fetch_fifo #(.DW(CHUNK_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(start_pulse), .push(push),
    .wdata(mem_rdata), .pop(pop), .rdata(chunk),
    .full(fifo_full), .empty(fifo_empty)
  );

  pcm_fetch_unpack #(.DW(CHUNK_W), .SAMPLE_W(SAMPLE_W), .POS_W(POS_W)) u_unpack (
    .clk(clk), .rst(rst), .start_pulse(start_pulse), .busy(busy),
    .smp_req(smp_req), .fifo_empty(fifo_empty), .chunk(chunk), .pop(pop),
    .smp_valid(smp_valid), .smp_data(smp_data), .pos(pos)
  );
endmodule

// File: tb/pcm_fetch_test.sv
module pcm_fetch_test;
  localparam int RI_CTRL = 0, RI_FIRST = 1, RI_LAST = 2, RI_FLAGS = 3, RI_EN = 4, RI_POS = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_idx = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         mem_req;
  logic [27:0]  mem_addr;
  logic         mem_gnt;
  logic [127:0] mem_rdata;
  logic         smp_req = 1'b0;
  logic         smp_valid;
  logic [15:0]  smp_data;
  logic         irq;

  int ncmp = 0, nfail = 0, lat = 0, nfetch = 0;
  int fetch_log [64];
  bit finished = 0;

  always #5 clk = ~clk;

  pcm_fetch uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .smp_req(smp_req), .smp_valid(smp_valid), .smp_data(smp_data), .irq(irq)
  );

  function automatic logic [15:0] model(input int chunk_no, input int k);
    return 16'((chunk_no * 8 + k) * 5 + 7);
  endfunction

  initial begin
    int wcnt = 0;
    mem_gnt = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_gnt = 1'b0;
      if (mem_req && !rst) begin
        if (wcnt >= lat) begin
          mem_gnt = 1'b1;
          for (int k = 0; k < 8; k++) mem_rdata[16*k +: 16] = model(int'(mem_addr) >> 4, k);
          if (nfetch < 64) fetch_log[nfetch] = int'(mem_addr);
          nfetch++;
          wcnt = 0;
        end else wcnt++;
      end else wcnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    ncmp++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = 3'(idx); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    reg_idx = 3'(idx);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic get_sample(output logic v, output logic [15:0] d);
    @(negedge clk);
    smp_req = 1'b1;
    @(negedge clk);
    smp_req = 1'b0;
    v = smp_valid;
    d = smp_data;
  endtask

  // consume n samples, expecting chunk sequence from first chunk fc over nch chunks
  task automatic consume(input int fc, input int nch, input int n, input bit check_last);
    logic v; logic [15:0] d; logic [31:0] r;
    for (int i = 0; i < n; i++) begin
      int tries = 0;
      int c = fc + (i / 8) % nch;
      if (check_last && i == n - 1) begin
        rd(RI_FLAGS, r);
        chk(r[1] == 1'b0, "R7", "finish flag before last sample", r, 1);
      end
      do begin
        get_sample(v, d);
        tries++;
      end while (!v && tries < 40);
      chk(v && d == model(c, i % 8), "R6", $sformatf("sample %0d", i), d, model(c, i % 8));
    end
  endtask

  task automatic play(input int first_a, input int last_a, input int l, input bit stall);
    logic [31:0] r;
    int fc = first_a >> 4;
    int nch = (last_a >> 4) - fc + 1;
    lat = l;
    wr(RI_FIRST, first_a);
    wr(RI_LAST, last_a);
    nfetch = 0;
    wr(RI_CTRL, 32'h1);
    rd(RI_FLAGS, r);
    chk(r[0] == 1'b1, "R7", "begin flag", r, 1);
    if (stall) begin
      repeat (40) @(negedge clk);
      chk(nfetch == 2 && !mem_req, "R5", "fetches with no consumption", nfetch, 2);
      wr(RI_FIRST, 32'h5000);
      wr(RI_LAST, 32'h6000);
      wr(RI_CTRL, 32'h2);
      rd(RI_FIRST, r);
      chk(r == (first_a & 32'h0FFF_FFF8), "R3", "first addr frozen", r, first_a & 32'h0FFF_FFF8);
      rd(RI_CTRL, r);
      chk(r == 32'h1, "R3", "control frozen", r, 1);
      chk(irq == 1'b0, "R9", "irq masked begin flag", irq, 0);
    end
    consume(fc, nch, nch * 8, 1'b1);
    rd(RI_CTRL, r);
    chk(r[0] == 1'b0, "R7", "busy cleared at end", r, 0);
    rd(RI_FLAGS, r);
    chk(r == 32'h3, "R7", "both flags after end", r, 3);
    rd(RI_POS, r);
    chk(r == 32'(nch * 8), "R10", "sample count", r, nch * 8);
    chk(nfetch == nch, "R4", "fetch count", nfetch, nch);
    for (int i = 0; i < nch && i < 64; i++)
      chk(fetch_log[i] == (fc + i) * 16, "R4", $sformatf("fetch addr %0d", i),
          fetch_log[i], (fc + i) * 16);
  endtask

  initial begin
    logic [31:0] r; logic v; logic [15:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      rd(i, r);
      chk(r == 0, "R1", $sformatf("reg %0d after reset", i), r, 0);
    end
    chk(!irq && !mem_req && !smp_valid, "R1", "outputs after reset", {irq, mem_req, smp_valid}, 0);
    // R2 writable bits
    wr(RI_FIRST, 32'hFFFF_FFFF);
    rd(RI_FIRST, r);
    chk(r == 32'h0FFF_FFF8, "R2", "first addr mask", r, 32'h0FFF_FFF8);
    wr(RI_LAST, 32'hFFFF_FFFF);
    rd(RI_LAST, r);
    chk(r == 32'h0FFF_FFF8, "R2", "last addr mask", r, 32'h0FFF_FFF8);
    // R12 idle requests
    get_sample(v, d);
    chk(!v, "R12", "idle sample request", v, 0);
    rd(RI_POS, r);
    chk(r == 0, "R12", "count unchanged when idle", r, 0);
    chk(!mem_req, "R12", "no fetch when idle", mem_req, 0);

    wr(RI_EN, 32'h2);
    play(32'h103, 32'h17F, 0, 1'b1);
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R9", "irq on enabled finish", irq, 1);
    // R8 write-one-to-clear
    wr(RI_FLAGS, 32'h0);
    rd(RI_FLAGS, r);
    chk(r == 32'h3, "R8", "write zero keeps flags", r, 3);
    wr(RI_FLAGS, 32'h1);
    rd(RI_FLAGS, r);
    chk(r == 32'h2, "R8", "clear begin only", r, 2);
    chk(irq == 1'b1, "R9", "irq still up", irq, 1);
    wr(RI_FLAGS, 32'h2);
    rd(RI_FLAGS, r);
    chk(r == 32'h0, "R8", "clear finish", r, 0);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R9", "irq dropped", irq, 0);

    // R12 idle after end
    get_sample(v, d);
    chk(!v, "R12", "request after end", v, 0);
    rd(RI_POS, r);
    chk(r == 64, "R12", "count held after end", r, 64);

    wr(RI_EN, 32'h0);
    play(32'h4A0, 32'h4A0, 2, 1'b0);
    chk(irq == 1'b0, "R9", "irq with enables off", irq, 0);
    wr(RI_FLAGS, 32'h3);
    play(32'hFFFFFE0, 32'hFFFFFF0, 3, 1'b0);
    wr(RI_FLAGS, 32'h3);
    play(32'h2008, 32'h2050, 1, 1'b0);
    rd(RI_FIRST, r);
    chk(r == 32'h2008, "R2", "bit 3 kept, fetch from 0x2000", r, 32'h2008);
    wr(RI_FLAGS, 32'h3);

    // R11 repeat mode
    lat = 1;
    wr(RI_FIRST, 32'h200);
    wr(RI_LAST, 32'h210);
    nfetch = 0;
    wr(RI_CTRL, 32'h3);
    consume(32'h20, 2, 40, 1'b0);
    rd(RI_CTRL, r);
    chk(r == 32'h3, "R11", "still busy with repeat", r, 3);
    rd(RI_FLAGS, r);
    chk(r == 32'h1, "R11", "no finish in repeat", r, 1);
    rd(RI_POS, r);
    chk(r == 40, "R10", "count in repeat", r, 40);
    for (int i = 0; i < 5; i++)
      chk(fetch_log[i] == (32'h20 + i % 2) * 16, "R11", $sformatf("repeat fetch %0d", i),
          fetch_log[i], (32'h20 + i % 2) * 16);

    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    rd(RI_CTRL, r);
    chk(r == 0, "R1", "control after second reset", r, 0);
    rd(RI_FLAGS, r);
    chk(r == 0, "R1", "flags after second reset", r, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      ncmp++;
      nfail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
      $finish;
    end
  end
endmodule